// File: doc/BRIEF.md
# Register-File LIFO with Full and Empty Flags

This block is a last-in-first-out store of 2^AW words, held in flip-flops and addressed by an AW-bit top-of-stack pointer (64 words and a 6-bit pointer by default). A holding register sits in front of it: a push copies the holding register onto the stack, and a pop copies the top word back into the holding register. The holding register can also be loaded from `data_in` without pushing, so the usual way to use the block is to load a value and push it, in the same cycle or in separate cycles.

The pointer counts modulo 2^AW. A push first advances the pointer and then writes the new top slot. A pop first reads the slot under the pointer and then steps the pointer back. The full flag rises when a push wraps the pointer to zero, and the empty flag rises when a pop brings it back to zero, so every slot is usable. A request that cannot be honoured changes no state and produces a one-cycle error pulse.

Top module: `regstack_lifo`

## Requirements
- R1: While and after reset, `empty` is 1, `full` is 0, `err` is 0 and `data_reg` is 0.
- R2: An accepted push (push_req=1, pop_req=0, full=0) stores the value `data_reg` held in the push cycle as the new top word and makes `empty` 0 from the next cycle.
- R3: Starting from empty, `full` becomes 1 after exactly 2^AW accepted pushes and stays 0 before that; `full` and `empty` are never 1 together.
- R4: An accepted pop (pop_req=1, push_req=0, empty=0) places the most recently pushed word that has not yet been popped into `data_reg` in the next cycle, so words come back in reverse order of pushing.
- R5: An accepted pop makes `full` 0, and `empty` becomes 1 when the pop removes the last stored word.
- R6: A push while `full`=1 raises `err` for the next cycle and leaves `data_reg`, the flags and the stored words unchanged.
- R7: A pop while `empty`=1 raises `err` for the next cycle and leaves `data_reg`, the flags and the stored words unchanged.
- R8: push_req and pop_req both at 1 in one cycle is an error: `err` is 1 in the next cycle, and the request, including any load_req, is ignored.
- R9: load_req=1 copies `data_in` into `data_reg` on the next edge unless the cycle carries an accepted pop or an error. With a push in the same cycle, the stack receives the old `data_reg` value.
- R10: `err` is a single-cycle pulse: it is 0 in the cycle after any cycle with an acceptable request or with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Push the holding register onto the stack |
| pop_req | input | 1 | Pop the top word into the holding register |
| load_req | input | 1 | Load the holding register from data_in |
| data_in | input | DW | Word for the holding register |
| data_reg | output | DW | Holding register contents |
| full | output | 1 | All 2^AW slots occupied |
| empty | output | 1 | No word stored |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The assertions expect the request inputs to be known and stable around each rising edge, and they place no restriction on combining them. Every combination, including push with pop and requests against a full or empty stack, is legal and has a defined outcome. The stimulus changes inputs only on falling edges. It fills the stack to the wrap point, drains it completely and then mixes requests pseudo-randomly, so each assertion has both its trigger and its non-trigger case exercised.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2,
      OP_BAD  = 2'd3
   } lifo_op_e;
endpackage

// File: rtl/lifo_decode.sv
module lifo_decode
   import lifo_pkg::*;
(
   input  logic     push_req,
   input  logic     pop_req,
   input  logic     full,
   input  logic     empty,
   output lifo_op_e op
);
   always_comb begin
      op = OP_IDLE;
      if (push_req && pop_req)  op = OP_BAD;
      else if (push_req)        op = full  ? OP_BAD : OP_PUSH;
      else if (pop_req)         op = empty ? OP_BAD : OP_POP;
   end
endmodule

// File: rtl/lifo_ptr.sv
module lifo_ptr
   import lifo_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  lifo_op_e      op,
   output logic [AW-1:0] sp,
   output logic [AW-1:0] sp_inc,
   output logic          full,
   output logic          empty
);
   logic [AW-1:0] sp_dec;

   assign sp_inc = sp + 1'b1;
   assign sp_dec = sp - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp    <= '0;
         full  <= 1'b0;
         empty <= 1'b1;
      end else begin
         case (op)
            OP_PUSH: begin
               sp    <= sp_inc;
               full  <= (sp_inc == '0);
               empty <= 1'b0;
            end
            OP_POP: begin
               sp    <= sp_dec;
               empty <= (sp_dec == '0);
               full  <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   p_full_at_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (sp == '0));
   p_empty_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (sp == '0));
   p_bad_keeps_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_BAD) |=> $stable(sp));
endmodule

// File: rtl/lifo_regfile.sv
module lifo_regfile #(
   parameter int DW          = 8,
   parameter int AW          = 6,
   parameter bit RESET_WORDS = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      if (RESET_WORDS) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)                                 words[i] <= '0;
            else if (we && (waddr == AW'(i)))           words[i] <= wdata;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i)))                words[i] <= wdata;
         end
      end
   end

   assign rdata = words[raddr];

   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (words[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/regstack_lifo.sv
module regstack_lifo
   import lifo_pkg::*;
#(
   parameter int DW          = 8,
   parameter int AW          = 6,
   parameter bit RESET_WORDS = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_req,
   input  logic          pop_req,
   input  logic          load_req,
   input  logic [DW-1:0] data_in,
   output logic [DW-1:0] data_reg,
   output logic          full,
   output logic          empty,
   output logic          err
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("regstack_lifo: AW out of range 1..10");
   end
   if (DW < 1) begin : g_bad_dw
      $error("regstack_lifo: DW must be at least 1");
   end

   lifo_op_e      op;
   logic [AW-1:0] sp;
   logic [AW-1:0] sp_inc;
   logic [DW-1:0] top_word;

   lifo_decode u_dec (
      .push_req (push_req),
      .pop_req  (pop_req),
      .full     (full),
      .empty    (empty),
      .op       (op)
   );

   lifo_ptr #(.AW(AW)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .sp     (sp),
      .sp_inc (sp_inc),
      .full   (full),
      .empty  (empty)
   );

   lifo_regfile #(.DW(DW), .AW(AW), .RESET_WORDS(RESET_WORDS)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (op == OP_PUSH),
      .waddr (sp_inc),
      .wdata (data_reg),
      .raddr (sp),
      .rdata (top_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_reg <= '0;
         err      <= 1'b0;
      end else begin
         err <= (op == OP_BAD);
         if (op == OP_POP)                      data_reg <= top_word;
         else if (load_req && op != OP_BAD)     data_reg <= data_in;
      end
   end

   p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
   p_push_clears_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && !pop_req && !full) |=> !empty);
   p_pop_clears_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !push_req && !empty) |=> !full);
   p_push_on_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && !pop_req && full) |=> (err && full && $stable(data_reg)));
   p_pop_on_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !push_req && empty) |=> (err && empty && $stable(data_reg)));
   p_both_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && pop_req) |=> (err && $stable(data_reg) && $stable(full) && $stable(empty)));
   p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && !push_req && !pop_req) |=> (data_reg == $past(data_in)));
   p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(push_req && pop_req) && !(push_req && full) && !(pop_req && empty)) |=> !err);
   p_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> ($past(sp) == AW'(DEPTH - 1)));
endmodule

// File: tb/tb_regstack_lifo.sv
module tb_regstack_lifo;
   localparam int DW    = 8;
   localparam int AW    = 6;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          push_req, pop_req, load_req;
   logic [DW-1:0] data_in;
   logic [DW-1:0] data_reg;
   logic          full, empty, err;

   regstack_lifo #(.DW(DW), .AW(AW)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (push_req),
      .pop_req  (pop_req),
      .load_req (load_req),
      .data_in  (data_in),
      .data_reg (data_reg),
      .full     (full),
      .empty    (empty),
      .err      (err)
   );

   always #10 clk = ~clk;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   logic [DW-1:0] m_mem [DEPTH];
   logic [AW-1:0] m_sp;
   logic          m_full, m_empty, m_err;
   logic [DW-1:0] m_dr;

   task automatic check(input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      check(tag, "data_reg", data_reg, m_dr);
      check(tag, "full", DW'(full), DW'(m_full));
      check(tag, "empty", DW'(empty), DW'(m_empty));
      check(tag, "err", DW'(err), DW'(m_err));
   endtask

   // one request cycle: drive on falling edge, compare at the following falling edge
   task automatic step(input logic p, input logic q, input logic l,
                       input logic [DW-1:0] d, input string tag);
      logic bad;
      push_req = p; pop_req = q; load_req = l; data_in = d;
      bad = (p && q) || (p && m_full) || (q && m_empty);
      m_err = bad;
      if (!bad) begin
         if (p) begin
            m_sp = m_sp + 1'b1;
            m_mem[m_sp] = m_dr;
            m_full = (m_sp == '0);
            m_empty = 1'b0;
            if (l) m_dr = d;
         end else if (q) begin
            m_dr = m_mem[m_sp];
            m_sp = m_sp - 1'b1;
            m_empty = (m_sp == '0);
            m_full = 1'b0;
         end else if (l) begin
            m_dr = d;
         end
      end
      @(negedge clk);
      compare_all(tag);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      rst_n = 1'b0; push_req = 0; pop_req = 0; load_req = 0; data_in = '0;
      m_sp = '0; m_full = 0; m_empty = 1; m_err = 0; m_dr = '0;
      repeat (3) @(negedge clk);
      compare_all("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1");

      // fill: alternate separate load+push with combined load+push (R2, R9, R3)
      for (int i = 0; i < DEPTH; i++) begin
         if (i % 2 == 0) begin
            step(0, 0, 1, DW'(i * 37 + 5), "R9");
            step(1, 0, 0, '0, "R2");
         end else begin
            step(1, 0, 1, DW'(i * 91 + 3), "R3");
         end
      end
      check("R3", "full after depth pushes", DW'(full), DW'(1));
      step(1, 0, 1, 8'hA5, "R6");
      step(0, 0, 0, '0, "R10");
      step(1, 1, 1, 8'h3C, "R8");
      step(0, 0, 0, '0, "R10");

      // drain completely, words must return in reverse order (R4, R5)
      for (int i = 0; i < DEPTH; i++)
         step(0, 1, (i % 3 == 0), DW'(i), "R4");
      check("R5", "empty after drain", DW'(empty), DW'(1));
      step(0, 1, 1, 8'h77, "R7");
      step(1, 1, 0, '0, "R8");
      step(0, 0, 1, 8'h5A, "R9");

      // pseudo-random mix of every request combination
      lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         logic p, q, l;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         // bias toward pushes in first half, pops in second, to reach both flags
         p = (i < 1500) ? (lfsr[2:0] != 3'd0) : (lfsr[2:0] == 3'd1);
         q = (i < 1500) ? (lfsr[5:3] == 3'd2) : (lfsr[5:3] != 3'd0);
         l = lfsr[6];
         step(p, q, l, lfsr[15:8], "R4");
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule